// File: doc/BRIEF.md
# Privileged Trap Entry and Return Sequencer

This block moves control from unprivileged code into a privileged handler and back again. Three sources can request entry: a software interrupt carrying an 8-bit vector, a timer tick, and an illegal attempt by unprivileged code to write the privilege bit. For each accepted request the sequencer latches the interrupted context. It then writes a six-word frame onto a kernel stack that is kept apart from the user stack, one word per cycle through a memory write port. Next it reads the handler address and the new privilege level from a 256-entry descriptor table, addressed by the vector, and loads both.

A return command reverses the sequence. It reads the frame back through a memory read port, skips the error word, restores instruction pointer, code segment, flags, stack pointer, stack segment and privilege level, and releases the frame from the kernel stack. Requests that arrive while a sequence is running are held and served in a fixed priority order.

Top module: `trap_seq`

## Requirements
- R1: After reset, `priv` is 0, `ksp` equals `KSP_TOP`, and `busy`, `ip_load` and `mem_we` are 0.
- R2: On trap entry the kernel stack grows downward in `DW/8`-byte words. One word is written per cycle on consecutive cycles, first at `ksp-4`, then at lower addresses. The order is user stack segment, user stack pointer, flags, code segment, instruction pointer, error code. `ksp` ends 24 bytes below its start.
- R3: The pushed flags word is `ctx_flags` with bit `PRIVPOS` (12) replaced by the privilege level in force when the trap was accepted.
- R4: After the frame is written, `tbl_idx` carries the vector, `ip_out` takes `tbl_ip` and `priv` takes `tbl_priv`. The vector is `swi_vec` for a software interrupt, `TMR_VEC` (32) for a tick and `VIOL_VEC` (13) for a violation.
- R5: The error code word is `VIOL_ERR` (1) for a violation trap and zero for timer and software traps.
- R6: `busy` is high from the cycle after the accepting edge. `ip_load` is a one-cycle pulse, seen after the 8th rising edge counted from the accepting edge. `busy` is low in that cycle.
- R7: `priv_wr` while `priv` is 0 raises a violation trap and leaves `priv` at 0. `priv_wr` while `priv` is 1, in an idle cycle with no trap accepted, sets `priv` to `priv_wdata`.
- R8: Requests that arrive while busy are held. Pending requests are served in this order: violation, timer, software interrupt, return.
- R9: A return reads the frame at `ksp+4` to `ksp+20`, skipping the error word. It restores `ip_out`, `cs_out`, `flags_out`, `sp_out` and `ss_out`, takes `priv` from bit 12 of the popped flags, and raises `ksp` by 24. `ip_load` is seen after the 6th edge counted from the accepting edge.
- R10: Memory writes happen only while busy, and a write and a read are never issued in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| swi_req | input | 1 | Software interrupt request |
| swi_vec | input | VW | Software interrupt vector |
| tick | input | 1 | Timer tick request |
| priv_wr | input | 1 | Attempt to write the privilege bit |
| priv_wdata | input | 1 | Value for the privilege bit |
| iret | input | 1 | Return-from-trap command |
| ctx_ss | input | DW | Current user stack segment |
| ctx_sp | input | DW | Current user stack pointer |
| ctx_flags | input | DW | Current flags |
| ctx_cs | input | DW | Current code segment |
| ctx_ip | input | DW | Current instruction pointer |
| tbl_idx | output | VW | Descriptor table index |
| tbl_ip | input | DW | Handler address from the table |
| tbl_priv | input | 1 | Privilege level on entry from the table |
| mem_we | output | 1 | Kernel stack write enable |
| mem_addr | output | DW | Kernel stack write byte address |
| mem_wdata | output | DW | Kernel stack write data |
| mem_re | output | 1 | Kernel stack read enable |
| mem_raddr | output | DW | Kernel stack read byte address |
| mem_rdata | input | DW | Kernel stack read data, same cycle |
| busy | output | 1 | Sequence in progress |
| ip_load | output | 1 | One-cycle pulse: new instruction pointer valid |
| ip_out | output | DW | Loaded instruction pointer |
| cs_out | output | DW | Restored code segment |
| flags_out | output | DW | Restored flags |
| sp_out | output | DW | Restored user stack pointer |
| ss_out | output | DW | Restored user stack segment |
| priv | output | 1 | Privilege bit |
| ksp | output | DW | Kernel stack pointer |

## Verification
The bench sets `KSP_TOP` to 0x100 and keeps the other defaults. Every frame therefore lands in a 64-word stack model that is checked word by word. Three nested frames fit, so the timer vector 32, the violation vector 13 and the error code 1 can all be seen in one run. The table model gives every vector a distinct handler address and clears the privilege flag only for vector 7, which makes entry into an unprivileged handler observable.

// File: rtl/trap_pkg.sv
package trap_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PUSH = 2'd1,
    ST_LOAD = 2'd2,
    ST_POP  = 2'd3
  } seq_st_t;

  localparam int FRAME_WORDS = 6;
  localparam int NSRC        = 4;
  // request slot positions, also the priority order (lowest wins)
  localparam int SRC_VIOL = 0;
  localparam int SRC_TICK = 1;
  localparam int SRC_SWI  = 2;
  localparam int SRC_RET  = 3;
endpackage

// File: rtl/trap_arb.sv
module trap_arb #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  input  logic         idle,
  output logic [N-1:0] grant,
  output logic [N-1:0] pend
);
  logic [N-1:0] cand;
  logic [N-1:0] pend_d;
  logic         found;

  assign cand = pend | req;

  always_comb begin
    grant = '0;
    found = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (idle && cand[i] && !found) begin
        grant[i] = 1'b1;
        found    = 1'b1;
      end
    end
    pend_d = cand & ~grant;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend <= '0;
    else        pend <= pend_d;
  end
endmodule

// File: rtl/trap_frame.sv
module trap_frame #(
  parameter int DW      = 32,
  parameter int PRIVPOS = 12
) (
  input  logic [2:0]    sel,
  input  logic          lvl,
  input  logic [DW-1:0] ss,
  input  logic [DW-1:0] sp,
  input  logic [DW-1:0] flags,
  input  logic [DW-1:0] cs,
  input  logic [DW-1:0] ip,
  input  logic [DW-1:0] err,
  output logic [DW-1:0] word
);
  logic [DW-1:0] fl_mix;

  always_comb begin
    fl_mix          = flags;
    fl_mix[PRIVPOS] = lvl;
    case (sel)
      3'd0:    word = ss;
      3'd1:    word = sp;
      3'd2:    word = fl_mix;
      3'd3:    word = cs;
      3'd4:    word = ip;
      default: word = err;
    endcase
  end
endmodule

// File: rtl/trap_seq.sv
module trap_seq #(
  parameter int              DW       = 32,
  parameter int              VW       = 8,
  parameter logic [DW-1:0]   KSP_TOP  = 32'h0000_1000,
  parameter logic [VW-1:0]   TMR_VEC  = 8'd32,
  parameter logic [VW-1:0]   VIOL_VEC = 8'd13,
  parameter logic [DW-1:0]   VIOL_ERR = 32'h0000_0001,
  parameter int              PRIVPOS  = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          swi_req,
  input  logic [VW-1:0] swi_vec,
  input  logic          tick,
  input  logic          priv_wr,
  input  logic          priv_wdata,
  input  logic          iret,
  input  logic [DW-1:0] ctx_ss,
  input  logic [DW-1:0] ctx_sp,
  input  logic [DW-1:0] ctx_flags,
  input  logic [DW-1:0] ctx_cs,
  input  logic [DW-1:0] ctx_ip,
  output logic [VW-1:0] tbl_idx,
  input  logic [DW-1:0] tbl_ip,
  input  logic          tbl_priv,
  output logic          mem_we,
  output logic [DW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          mem_re,
  output logic [DW-1:0] mem_raddr,
  input  logic [DW-1:0] mem_rdata,
  output logic          busy,
  output logic          ip_load,
  output logic [DW-1:0] ip_out,
  output logic [DW-1:0] cs_out,
  output logic [DW-1:0] flags_out,
  output logic [DW-1:0] sp_out,
  output logic [DW-1:0] ss_out,
  output logic          priv,
  output logic [DW-1:0] ksp
);
  import trap_pkg::*;

  localparam logic [DW-1:0] WB          = DW'(DW / 8);
  localparam logic [DW-1:0] FRAME_BYTES = DW'(FRAME_WORDS * (DW / 8));
  localparam logic [2:0]    LAST_IDX    = 3'(FRAME_WORDS - 1);

  seq_st_t       st_q, st_d;
  logic [2:0]    idx_q, idx_d;
  logic [VW-1:0] vec_q, vec_d, swv_q, swv_d;
  logic [DW-1:0] err_q, err_d;
  logic [DW-1:0] fss_q, fss_d, fsp_q, fsp_d, ffl_q, ffl_d, fcs_q, fcs_d, fip_q, fip_d;
  logic          lvl_q, lvl_d;
  logic [DW-1:0] rip_q, rip_d, rcs_q, rcs_d, rfl_q, rfl_d, rsp_q, rsp_d;
  logic [DW-1:0] ip_d, cs_d, fl_d, sp_d, ss_d, ksp_d;
  logic          priv_d, load_d;
  logic [NSRC-1:0] req, grant, pend;
  logic          idle;

  assign idle = (st_q == ST_IDLE);
  assign req[SRC_VIOL] = priv_wr & ~priv;
  assign req[SRC_TICK] = tick;
  assign req[SRC_SWI]  = swi_req;
  assign req[SRC_RET]  = iret;

  trap_arb #(.N(NSRC)) u_arb (
    .clk(clk), .rst_n(rst_n), .req(req), .idle(idle), .grant(grant), .pend(pend)
  );

  trap_frame #(.DW(DW), .PRIVPOS(PRIVPOS)) u_frame (
    .sel(idx_q), .lvl(lvl_q), .ss(fss_q), .sp(fsp_q), .flags(ffl_q),
    .cs(fcs_q), .ip(fip_q), .err(err_q), .word(mem_wdata)
  );

  assign busy      = !idle;
  assign tbl_idx   = vec_q;
  assign mem_we    = (st_q == ST_PUSH);
  assign mem_addr  = ksp - WB;
  assign mem_re    = (st_q == ST_POP);
  assign mem_raddr = ksp + DW'(idx_q) * WB;

  always_comb begin
    st_d = st_q;   idx_d = idx_q;  vec_d = vec_q;  err_d = err_q;
    fss_d = fss_q; fsp_d = fsp_q;  ffl_d = ffl_q;  fcs_d = fcs_q; fip_d = fip_q;
    lvl_d = lvl_q; rip_d = rip_q;  rcs_d = rcs_q;  rfl_d = rfl_q; rsp_d = rsp_q;
    ip_d = ip_out; cs_d = cs_out;  fl_d = flags_out; sp_d = sp_out; ss_d = ss_out;
    ksp_d = ksp;   priv_d = priv;  load_d = 1'b0;
    swv_d = (swi_req && !pend[SRC_SWI]) ? swi_vec : swv_q;
    case (st_q)
      ST_IDLE: begin
        if (|grant[SRC_SWI:SRC_VIOL]) begin
          fss_d = ctx_ss; fsp_d = ctx_sp; ffl_d = ctx_flags;
          fcs_d = ctx_cs; fip_d = ctx_ip; lvl_d = priv;
          idx_d = 3'd0;   st_d = ST_PUSH;
          err_d = grant[SRC_VIOL] ? VIOL_ERR : '0;
          if (grant[SRC_VIOL])      vec_d = VIOL_VEC;
          else if (grant[SRC_TICK]) vec_d = TMR_VEC;
          else                      vec_d = pend[SRC_SWI] ? swv_q : swi_vec;
        end else if (grant[SRC_RET]) begin
          idx_d = 3'd1;  st_d = ST_POP;
        end else if (priv_wr && priv) begin
          priv_d = priv_wdata;
        end
      end
      ST_PUSH: begin
        ksp_d = ksp - WB;
        if (idx_q == LAST_IDX) st_d = ST_LOAD;
        else                   idx_d = idx_q + 3'd1;
      end
      ST_LOAD: begin
        ip_d = tbl_ip; priv_d = tbl_priv; load_d = 1'b1; st_d = ST_IDLE;
      end
      default: begin
        idx_d = idx_q + 3'd1;
        case (idx_q)
          3'd1: rip_d = mem_rdata;
          3'd2: rcs_d = mem_rdata;
          3'd3: rfl_d = mem_rdata;
          3'd4: rsp_d = mem_rdata;
          default: begin
            ss_d = mem_rdata; ip_d = rip_q; cs_d = rcs_q; fl_d = rfl_q; sp_d = rsp_q;
            priv_d = rfl_q[PRIVPOS]; ksp_d = ksp + FRAME_BYTES;
            load_d = 1'b1; st_d = ST_IDLE;
          end
        endcase
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE; idx_q <= '0; vec_q <= '0; swv_q <= '0; err_q <= '0;
      fss_q <= '0; fsp_q <= '0; ffl_q <= '0; fcs_q <= '0; fip_q <= '0; lvl_q <= 1'b0;
      rip_q <= '0; rcs_q <= '0; rfl_q <= '0; rsp_q <= '0;
      ip_out <= '0; cs_out <= '0; flags_out <= '0; sp_out <= '0; ss_out <= '0;
      ksp <= KSP_TOP; priv <= 1'b0; ip_load <= 1'b0;
    end else begin
      st_q <= st_d; idx_q <= idx_d; vec_q <= vec_d; swv_q <= swv_d; err_q <= err_d;
      fss_q <= fss_d; fsp_q <= fsp_d; ffl_q <= ffl_d; fcs_q <= fcs_d; fip_q <= fip_d;
      lvl_q <= lvl_d;
      rip_q <= rip_d; rcs_q <= rcs_d; rfl_q <= rfl_d; rsp_q <= rsp_d;
      ip_out <= ip_d; cs_out <= cs_d; flags_out <= fl_d; sp_out <= sp_d; ss_out <= ss_d;
      ksp <= ksp_d; priv <= priv_d; ip_load <= load_d;
    end
  end
endmodule

// File: rtl/trap_seq_chk.sv
module trap_seq_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          priv_wr,
  input logic          busy,
  input logic          ip_load,
  input logic          mem_we,
  input logic          mem_re,
  input logic [DW-1:0] mem_addr,
  input logic          priv,
  input logic [DW-1:0] ksp
);
  // R2: each stack write leaves the pointer at the written address
  a_r2_push_moves_ksp: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> (ksp == $past(mem_addr)));

  // R6: leaving the busy phase always coincides with the load pulse
  a_r6_load_at_release: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> ip_load);

  // R6: the load pulse lasts a single cycle
  a_r6_load_single: assert property (@(posedge clk) disable iff (!rst_n)
    ip_load |=> !ip_load);

  // R7: an unprivileged write leaves the privilege bit clear
  a_r7_unpriv_write_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (priv_wr && !priv && !busy) |=> !priv);

  // R10: stack writes only inside a sequence
  a_r10_write_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> busy);

  // R10: never read and write the stack together
  a_r10_no_rw_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re));
endmodule

bind trap_seq trap_seq_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .priv_wr(priv_wr), .busy(busy), .ip_load(ip_load),
  .mem_we(mem_we), .mem_re(mem_re), .mem_addr(mem_addr), .priv(priv), .ksp(ksp)
);

// File: tb/trap_seq_bench.sv
module trap_seq_bench;
  localparam int          DW   = 32;
  localparam logic [31:0] TOP  = 32'h100;
  localparam logic [31:0] VERR = 32'h1;
  localparam logic [31:0] PBIT = 32'h1 << 12;

  typedef struct packed {
    logic [7:0]  vec;
    logic [31:0] ss, sp, fl, cs, ip;
  } stim_t;

  localparam stim_t STIM [4] = '{
    '{8'd0,   32'h0000_0023, 32'h7fff_fff0, 32'h0000_0202, 32'h0000_001b, 32'h0040_1000},
    '{8'd255, 32'h0000_002b, 32'h7fff_0000, 32'h0000_1246, 32'h0000_0033, 32'h0040_2abc},
    '{8'd7,   32'h1111_0001, 32'h2222_0002, 32'hffff_ffff, 32'h4444_0004, 32'h5555_0005},
    '{8'd42,  32'h0a0a_0a0a, 32'h0b0b_0b0b, 32'h0000_0000, 32'h0d0d_0d0d, 32'h0e0e_0e0e}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic swi_req = 0, tick = 0, priv_wr = 0, priv_wdata = 0, iret = 0;
  logic [7:0]  swi_vec = '0;
  logic [31:0] ctx_ss = '0, ctx_sp = '0, ctx_flags = '0, ctx_cs = '0, ctx_ip = '0;
  logic [7:0]  tbl_idx;
  logic [31:0] tbl_ip, mem_addr, mem_wdata, mem_raddr, mem_rdata;
  logic        tbl_priv, mem_we, mem_re, busy, ip_load, priv;
  logic [31:0] ip_out, cs_out, flags_out, sp_out, ss_out, ksp;
  logic [31:0] mem [64];
  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  function automatic logic [31:0] tip(input logic [7:0] v);
    return 32'h8000_0000 | (32'(v) << 4);
  endfunction
  function automatic logic tpriv(input logic [7:0] v);
    return v != 8'd7;
  endfunction

  assign tbl_ip    = tip(tbl_idx);
  assign tbl_priv  = tpriv(tbl_idx);
  assign mem_rdata = mem[mem_raddr[7:2]];
  always @(posedge clk) if (mem_we) mem[mem_addr[7:2]] <= mem_wdata;

  trap_seq #(.KSP_TOP(TOP)) u_trap_seq (
    .clk(clk), .rst_n(rst_n), .swi_req(swi_req), .swi_vec(swi_vec), .tick(tick),
    .priv_wr(priv_wr), .priv_wdata(priv_wdata), .iret(iret),
    .ctx_ss(ctx_ss), .ctx_sp(ctx_sp), .ctx_flags(ctx_flags), .ctx_cs(ctx_cs), .ctx_ip(ctx_ip),
    .tbl_idx(tbl_idx), .tbl_ip(tbl_ip), .tbl_priv(tbl_priv),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_re(mem_re), .mem_raddr(mem_raddr), .mem_rdata(mem_rdata),
    .busy(busy), .ip_load(ip_load), .ip_out(ip_out), .cs_out(cs_out),
    .flags_out(flags_out), .sp_out(sp_out), .ss_out(ss_out), .priv(priv), .ksp(ksp)
  );

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wait_load(output int n);
    n = 1;
    while (!ip_load && n < 64) begin
      step();
      n++;
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    step(); step();
    rst_n = 1'b1;
    step();
  endtask

  task automatic set_ctx(input stim_t s);
    ctx_ss = s.ss; ctx_sp = s.sp; ctx_flags = s.fl; ctx_cs = s.cs; ctx_ip = s.ip;
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual %h expected %h", 32'd1, 32'd0);
    report();
  end

  initial begin
    int n;
    logic [31:0] seen [4];
    stim_t c;
    @(negedge clk);
    do_reset();
    // R1: reset state
    chk(priv == 1'b0, "R1 priv", 32'(priv), 0);
    chk(ksp == TOP, "R1 ksp", ksp, TOP);
    chk(!busy && !ip_load && !mem_we, "R1 idle outputs", {busy, ip_load, mem_we}, 0);

    // vector walk: software trap then return, from privilege level 0
    for (int i = 0; i < 4; i++) begin
      c = STIM[i];
      set_ctx(c);
      swi_vec = c.vec; swi_req = 1'b1;
      step();
      swi_req = 1'b0;
      chk(busy, "R6 busy after accept", 32'(busy), 1);
      wait_load(n);
      chk(n == 8, "R6 entry latency", 32'(n), 8);
      chk(!busy, "R6 busy low at load", 32'(busy), 0);
      chk(ip_out == tip(c.vec), "R4 handler ip", ip_out, tip(c.vec));
      chk(priv == tpriv(c.vec), "R4 table privilege", 32'(priv), 32'(tpriv(c.vec)));
      chk(ksp == TOP - 24, "R2 ksp after push", ksp, TOP - 24);
      chk(mem[63] == c.ss, "R2 frame ss", mem[63], c.ss);
      chk(mem[62] == c.sp, "R2 frame sp", mem[62], c.sp);
      chk(mem[61] == (c.fl & ~PBIT), "R3 frame flags", mem[61], c.fl & ~PBIT);
      chk(mem[60] == c.cs, "R2 frame cs", mem[60], c.cs);
      chk(mem[59] == c.ip, "R2 frame ip", mem[59], c.ip);
      chk(mem[58] == 32'h0, "R5 zero error word", mem[58], 0);
      set_ctx('{8'd0, 32'hdead_0001, 32'hdead_0002, 32'hdead_0003, 32'hdead_0004, 32'hdead_0005});
      step();
      iret = 1'b1;
      step();
      iret = 1'b0;
      wait_load(n);
      chk(n == 6, "R9 return latency", 32'(n), 6);
      chk(ip_out == c.ip, "R9 restored ip", ip_out, c.ip);
      chk(cs_out == c.cs, "R9 restored cs", cs_out, c.cs);
      chk(flags_out == (c.fl & ~PBIT), "R9 restored flags", flags_out, c.fl & ~PBIT);
      chk(sp_out == c.sp && ss_out == c.ss, "R9 restored sp/ss", sp_out, c.sp);
      chk(priv == 1'b0, "R9 restored privilege", 32'(priv), 0);
      chk(ksp == TOP, "R9 ksp after pop", ksp, TOP);
      step();
    end

    // privilege writes: unprivileged attempt traps
    c = STIM[0];
    set_ctx(c);
    priv_wr = 1'b1; priv_wdata = 1'b1;
    step();
    priv_wr = 1'b0;
    chk(priv == 1'b0 && busy, "R7 unprivileged write traps", 32'(priv), 0);
    wait_load(n);
    chk(ip_out == tip(8'd13), "R4 violation vector", ip_out, tip(8'd13));
    chk(mem[58] == VERR, "R5 violation error word", mem[58], VERR);
    chk(priv == 1'b1, "R4 handler privileged", 32'(priv), 1);
    step();
    // nested software trap from privileged level
    ctx_flags = 32'h0000_0002; swi_vec = 8'd9; swi_req = 1'b1;
    step();
    swi_req = 1'b0;
    wait_load(n);
    chk(mem[55] == (32'h2 | PBIT), "R3 flags carry level 1", mem[55], 32'h2 | PBIT);
    chk(ksp == TOP - 48, "R2 nested frame", ksp, TOP - 48);
    step();
    iret = 1'b1;
    step();
    iret = 1'b0;
    wait_load(n);
    chk(priv == 1'b1 && ksp == TOP - 24, "R9 privileged level restored", 32'(priv), 1);
    step();
    priv_wr = 1'b1; priv_wdata = 1'b0;
    step();
    priv_wr = 1'b0;
    chk(priv == 1'b0 && !busy, "R7 privileged write applies", 32'(priv), 0);
    iret = 1'b1;
    step();
    iret = 1'b0;
    wait_load(n);
    chk(ip_out == c.ip && priv == 1'b0, "R9 return to user", ip_out, c.ip);
    chk(ksp == TOP, "R9 stack empty again", ksp, TOP);

    // priority and pending
    do_reset();
    chk(ksp == TOP && priv == 1'b0, "R1 reset after use", ksp, TOP);
    c = STIM[3];
    set_ctx(c);
    tick = 1'b1; swi_req = 1'b1; swi_vec = 8'd9; priv_wr = 1'b1; priv_wdata = 1'b1;
    step();
    tick = 1'b0; swi_req = 1'b0; priv_wr = 1'b0;
    iret = 1'b1;
    step();
    iret = 1'b0;
    for (int k = 0; k < 4; k++) begin
      wait_load(n);
      seen[k] = ip_out;
      step();
    end
    chk(seen[0] == tip(8'd13), "R8 violation first", seen[0], tip(8'd13));
    chk(seen[1] == tip(8'd32), "R8 timer second", seen[1], tip(8'd32));
    chk(seen[2] == tip(8'd9), "R8 software third", seen[2], tip(8'd9));
    chk(seen[3] == c.ip, "R8 held return last", seen[3], c.ip);
    chk(ksp == TOP - 48, "R8 stack after held return", ksp, TOP - 48);
    chk(mem[58] == VERR && mem[52] == 32'h0, "R5 error words", mem[52], 0);

    report();
  end
endmodule